// File: doc/BRIEF.md
# First-Come-First-Served Bus Arbiter

This block shares one external bus between a CPU and three secondary masters: a DMA engine, a display refresh engine and a DRAM refresh engine. The CPU owns the bus by default. Each secondary master raises its own request line. It may drive the bus only after its grant line goes high. There is no fixed or rotating priority. Requests are served strictly in the order in which they arrived.

While any secondary master is waiting or owns the bus, the arbiter freezes the CPU through a hold output. The freeze covers everything, non-maskable interrupt service included. When the hold is removed, a one-cycle resume pulse tells the CPU it may continue. A 2-bit owner code steers the address and data multiplexers.

A master gives the bus back by dropping its request. Its grant clears on the next cycle. At least one cycle with no grant separates two owners. A request that is dropped before it has been granted leaves the queue and is never served.

Top module: `fcfs_bus_arbiter`

## Requirements
- R1: During and directly after reset, `gnt` is 000, `cpu_hold` is 0, `cpu_resume` is 0 and `owner` is 0.
- R2: A request raised while the CPU owns the bus sets `cpu_hold` in the following cycle, with `gnt` still 000. The grant appears one cycle after that, so `cpu_hold` always rises one cycle before the first grant.
- R3: Requests raised in different cycles are granted in the order in which they arrived, whatever their indices.
- R4: Requests that first appear in the same cycle are queued in ascending index order: index 0 first, then 1, then 2.
- R5: At most one grant bit is high at any time. While one master owns the bus, the other requests stay pending and receive no grant.
- R6: When the owner's request is low in a cycle, its grant is low in the next cycle. A grant never passes directly from one master to another: a cycle with `gnt` = 000 always lies between two owners.
- R7: `cpu_hold` stays high while any grant is active or any request is queued. It drops one cycle after the arbiter finds the queue empty and no grant active. `cpu_resume` is high for exactly the first cycle in which `cpu_hold` is low again.
- R8: `owner` is 0 when no grant is active. It is i+1 while `gnt[i]` is high (bit 0 gives 1, bit 1 gives 2, bit 2 gives 3).
- R9: A queued request that is withdrawn before its grant is removed from the queue and is never granted.
- R10: A grant bit rises only for a master whose request was high in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 3 | Request lines of the three secondary masters |
| gnt | output | 3 | One-hot grant to the secondary masters |
| cpu_hold | output | 1 | Freezes the CPU, non-maskable interrupt handling included |
| cpu_resume | output | 1 | One-cycle pulse when the CPU may continue |
| owner | output | 2 | Current bus master: 0 is the CPU, 1 to 3 are the secondary masters |

## Verification
The assertions assume nothing about `req` beyond it being synchronous to `clk`. Any pattern is legal: a master may withdraw while waiting, an owner may release at any time, and a released master may request again in the idle gap. The stimulus keeps each request bit at its value for several cycles and toggles it with a low probability. This gives long ownerships, queues that fill to all three entries, requests that arrive in the same cycle, and withdrawals mixed with releases. Directed sequences before the random phase force ascending tie-break, reversed arrival order, withdrawal of a queued request, and the drop of hold when the queue is empty.

// File: rtl/fcfs_bus_arbiter.sv
module fcfs_bus_arbiter #(
  parameter int NREQ = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req,
  output logic [NREQ-1:0]          gnt,
  output logic                     cpu_hold,
  output logic                     cpu_resume,
  output logic [$clog2(NREQ+1)-1:0] owner
);
  localparam int OW = $clog2(NREQ+1);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  typedef enum logic [1:0] {ST_CPU, ST_WAIT, ST_OWN} st_t;

  st_t            st, st_n;
  logic [IW-1:0]  own;
  logic [NREQ-1:0] pend, pend_n, live, arrive, cand;
  logic [NREQ-1:0] older   [NREQ];
  logic [NREQ-1:0] older_n [NREQ];
  logic [IW-1:0]  head;
  logic           take;

  assign live   = pend & req;
  assign arrive = req & ~pend & ~gnt;

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      cand[i] = live[i];
      for (int j = 0; j < NREQ; j++)
        if (j != i && live[j] && !older[i][j]) cand[i] = 1'b0;
    end
  end

  always_comb begin
    head = '0;
    for (int i = NREQ-1; i >= 0; i--)
      if (cand[i]) head = IW'(i);
  end

  assign take = (st == ST_WAIT) && (|cand);

  always_comb begin
    st_n = st;
    case (st)
      ST_CPU:  if (|req) st_n = ST_WAIT;
      ST_WAIT: if (take) st_n = ST_OWN;
               else if (!(|req)) st_n = ST_CPU;
      ST_OWN:  if (!req[own]) st_n = ST_WAIT;
      default: st_n = ST_CPU;
    endcase
  end

  always_comb begin
    pend_n = (pend & req & ~(take ? cand : '0)) | arrive;
    for (int i = 0; i < NREQ; i++)
      for (int j = 0; j < NREQ; j++) begin
        older_n[i][j] = older[i][j];
        if (i != j) begin
          if (arrive[i] && arrive[j]) older_n[i][j] = (i < j);
          else if (arrive[j])         older_n[i][j] = 1'b1;
          else if (arrive[i])         older_n[i][j] = 1'b0;
        end
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_CPU;
      own        <= '0;
      pend       <= '0;
      gnt        <= '0;
      owner      <= '0;
      cpu_hold   <= 1'b0;
      cpu_resume <= 1'b0;
      for (int i = 0; i < NREQ; i++) older[i] <= '0;
    end else begin
      st         <= st_n;
      pend       <= pend_n;
      cpu_hold   <= (st_n != ST_CPU);
      cpu_resume <= (st == ST_WAIT) && (st_n == ST_CPU);
      for (int i = 0; i < NREQ; i++) older[i] <= older_n[i];
      if (take) begin
        own   <= head;
        gnt   <= cand;
        owner <= OW'(head) + OW'(1);
      end else if (st == ST_OWN && !req[own]) begin
        gnt   <= '0;
        owner <= '0;
      end
    end
  end

  p_onehot_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_hold_covers_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> cpu_hold);

  p_hold_before_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|gnt) |-> $past(cpu_hold));

  p_release_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|(gnt & req))) |=> (gnt == '0));

  p_no_handover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && $past(|gnt)) |-> (gnt == $past(gnt)));

  p_owner_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) == (owner == '0));

  p_grant_requested_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !$past(|gnt)) |-> (|(gnt & $past(req))));

  p_resume_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resume |-> (!cpu_hold && $past(cpu_hold)));
endmodule

// File: tb/fcfs_bus_arbiter_tb.sv
module fcfs_bus_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0;
  logic [2:0] gnt;
  logic       cpu_hold, cpu_resume;
  logic [1:0] owner;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int mq[3];
  int mcnt = 0, mst = 0, mown = 0;
  bit mres = 0;

  always #4 clk = ~clk;

  fcfs_bus_arbiter u_dut (.clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
    .cpu_hold(cpu_hold), .cpu_resume(cpu_resume), .owner(owner));

  function automatic logic [2:0] exp_gnt();
    return (mst == 2) ? 3'(1 << mown) : 3'b000;
  endfunction
  function automatic logic [1:0] exp_owner();
    return (mst == 2) ? 2'(mown + 1) : 2'd0;
  endfunction

  function automatic void model_step(input logic [2:0] r);
    int head, nst, nc;
    int nq[3];
    bit inq;
    head = -1;
    for (int k = 0; k < mcnt; k++)
      if (r[mq[k]] && head < 0) head = mq[k];
    nst = mst;
    mres = 0;
    case (mst)
      0: if (r != 0) nst = 1;
      1: if (head >= 0) nst = 2;
         else if (r == 0) begin nst = 0; mres = 1; end
      default: if (!r[mown]) nst = 1;
    endcase
    nc = 0;
    for (int k = 0; k < mcnt; k++)
      if (r[mq[k]] && !(mst == 1 && mq[k] == head)) begin nq[nc] = mq[k]; nc++; end
    for (int i = 0; i < 3; i++) begin
      inq = 0;
      for (int k = 0; k < mcnt; k++) if (mq[k] == i) inq = 1;
      if (r[i] && !inq && !(mst == 2 && mown == i)) begin nq[nc] = i; nc++; end
    end
    if (mst == 1 && head >= 0) mown = head;
    for (int k = 0; k < nc; k++) mq[k] = nq[k];
    mcnt = nc;
    mst = nst;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [2:0] r, input string tag);
    req = r;
    model_step(r);
    @(posedge clk); #2;
    chk(gnt, exp_gnt(), {tag, " gnt R3 R5 R9 R10"});
    chk(cpu_hold, int'(mst != 0), {tag, " hold R7"});
    chk(owner, exp_owner(), {tag, " owner R8"});
    chk(cpu_resume, mres, {tag, " resume R7"});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] r;
    int dummy;
    dummy = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #2;
    chk(gnt, 0, "R1 gnt in reset");
    chk(cpu_hold, 0, "R1 hold in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk(gnt, 0, "R1 gnt"); chk(cpu_hold, 0, "R1 hold");
    chk(owner, 0, "R1 owner"); chk(cpu_resume, 0, "R1 resume");
    @(negedge clk);

    cyc(3'b010, "R2");
    chk(cpu_hold, 1, "R2 hold early"); chk(gnt, 0, "R2 no grant yet");
    cyc(3'b010, "R2");
    chk(gnt, 3'b010, "R2 grant"); chk(owner, 2, "R8 owner of 1");
    cyc(3'b010, "R2");
    cyc(3'b000, "R6");
    chk(gnt, 0, "R6 release"); chk(cpu_hold, 1, "R7 hold in gap");
    cyc(3'b000, "R7");
    chk(cpu_hold, 0, "R7 hold drop"); chk(cpu_resume, 1, "R7 resume");

    cyc(3'b111, "R4");
    cyc(3'b111, "R4"); chk(gnt, 3'b001, "R4 first 0");
    cyc(3'b110, "R6"); chk(gnt, 3'b000, "R6 gap");
    cyc(3'b110, "R4"); chk(gnt, 3'b010, "R4 then 1");
    cyc(3'b100, "R4");
    cyc(3'b100, "R4"); chk(gnt, 3'b100, "R4 then 2");
    cyc(3'b000, "R7"); cyc(3'b000, "R7");

    cyc(3'b100, "R3"); cyc(3'b100, "R3");
    cyc(3'b110, "R5"); cyc(3'b111, "R5");
    chk(gnt, 3'b100, "R5 others wait");
    cyc(3'b011, "R6"); cyc(3'b011, "R3");
    chk(gnt, 3'b010, "R3 earlier arrival 1 first");
    cyc(3'b001, "R3"); cyc(3'b001, "R3");
    chk(gnt, 3'b001, "R3 later arrival 0");
    cyc(3'b000, "R7"); cyc(3'b000, "R7");

    cyc(3'b100, "R9"); cyc(3'b100, "R9");
    cyc(3'b101, "R9"); cyc(3'b100, "R9");
    cyc(3'b000, "R9"); cyc(3'b000, "R9");
    chk(gnt, 0, "R9 withdrawn not granted");
    chk(cpu_hold, 0, "R9 hold released");

    r = 3'b000;
    for (int n = 0; n < 6000; n++) begin
      for (int b = 0; b < 3; b++)
        if ($urandom_range(7) == 0) r[b] = ~r[b];
      cyc(r, "rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule